// File: doc/BRIEF.md
# Indirect Interrupt-Router Register File

This block is the software-visible register file of an interrupt routing controller. A bus master reaches it through two decoded offsets: a select register, which names one internal word, and a data window, which reads or writes the word the select register currently names. Behind the window sit a version word, an identification word, an arbitration word, and a table of 64-bit per-pin routing entries. Each table entry is exposed as two 32-bit halves at neighbouring select values.

Each routing entry holds a vector, a delivery mode, a destination mode, a polarity bit, a trigger mode, a remote-acknowledge flag, a mask bit and a destination. The block does not deliver interrupts. It keeps a per-pin pending register that external logic sets and clears. Whenever an entry is written, the block raises a one-cycle service request for that pin if the pin's pending bit is set. Whenever a write flips a pin's mask bit, it raises a one-cycle mask-change notice that carries the pin and the new mask value.

The design has no state machine. A write completes in the cycle it is presented. Reads, service requests and mask-change notices are all registered, so each appears exactly one cycle after the bus request.

Top module: `irq_route_regs`

## Requirements
- R1: Reset sets the mask bit (bit 16) of every entry and clears every other entry bit, the select register, the pending register and the 4-bit ID. After reset, a low-half read of any entry returns 0x00010000.
- R2: The select register sits at offset 0x00. It holds the low 8 bits of a written word, and reads return it zero-extended.
- R3: Through the window at offset 0x10, select value 0x01 reads the version word. The version word is the pin count minus one in bits 23:16 and the code 0x11 in bits 7:0, which gives 0x00170011 for 24 pins. Writes to it have no effect.
- R4: Select value 0x00 holds the ID in bits 27:24, and a write there updates only those bits. Select value 0x02 reads back the same ID word, and writes to it are ignored.
- R5: A select value S of 0x10 or above addresses entry (S-0x10)>>1. An odd S reaches entry bits 63:32 and an even S reaches bits 31:0. A write to one half leaves the other half unchanged.
- R6: A low-half entry write always clears the remote-acknowledge flag (bit 14), whatever the written data holds in that bit.
- R7: An entry index at or above the pin count is out of range. A write to it is discarded and raises no notice or service request, and a read of it returns zero.
- R8: One cycle after a low-half write that changes an entry's mask bit, the block pulses the mask-change output for one cycle with the pin index and the new mask. A write that leaves the mask unchanged raises no notice.
- R9: Each pending bit is set by a one-cycle pulse on its set line and cleared by a pulse on its clear line; set wins if both arrive together. One cycle after any accepted entry write (either half), a service request pulses for that pin if its pending bit was set at the write; otherwise no request is raised.
- R10: Only writes with a byte length of 4 or 8 are accepted. A write of any other length changes nothing and raises nothing.
- R11: Only bus address bits 7:0 are decoded. Reads return data one cycle after the request. A read of an undecoded offset, or of a window select value in 0x03 to 0x0F, returns zero. The read-data output is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write request, one cycle |
| bus_rd_en | input | 1 | Read request, one cycle |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 are decoded |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd_en |
| pend_set | input | NUM_PINS (24) | Per-pin pending set pulses |
| pend_clr | input | NUM_PINS (24) | Per-pin pending clear pulses |
| svc_valid | output | 1 | Service request pulse |
| svc_pin | output | PIN_W (5) | Pin of the service request |
| mask_chg_valid | output | 1 | Mask-change notice pulse |
| mask_chg_pin | output | PIN_W (5) | Pin whose mask changed |
| mask_chg_value | output | 1 | New mask value |

## Verification
The assertions check every cycle that read data is zero unless a read preceded it, and that a version read returns the computed word. They also check that each mask-change notice follows a write, names a valid pin and matches that pin's stored mask, and that each service request follows an entry write. Finally, they check that out-of-range writes and writes with a rejected length leave no trace. Only the bench scenarios can show the effects that depend on data: the half-entry mapping, the forced clearing of the remote flag, the ID readback through the arbitration slot, and the pending-bit interplay across set, clear and reset.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam logic [7:0] OFF_SELECT   = 8'h00;
    localparam logic [7:0] OFF_WINDOW   = 8'h10;
    localparam logic [7:0] IDX_IDENT    = 8'h00;
    localparam logic [7:0] IDX_VERSION  = 8'h01;
    localparam logic [7:0] IDX_ARBIT    = 8'h02;
    localparam logic [7:0] IDX_TBL_BASE = 8'h10;
    localparam logic [7:0] VERSION_CODE = 8'h11;
    localparam int         MASK_BIT     = 16;
    localparam int         RACK_BIT     = 14;

    typedef enum logic [2:0] {
        ACC_SELECT,
        ACC_IDENT,
        ACC_VERSION,
        ACC_ARBIT,
        ACC_ENT_LO,
        ACC_ENT_HI,
        ACC_UNMAPPED
    } acc_kind_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        sel,
    output acc_kind_e         kind,
    output logic [PIN_W-1:0]  idx
);
    logic [7:0] rel;
    logic [6:0] ent;
    logic [7:0] offset;
    logic       unused_hi;

    assign offset    = addr[7:0];
    assign unused_hi = ^addr[ADDR_W-1:8];
    assign rel       = sel - IDX_TBL_BASE;
    assign ent       = rel[7:1];
    assign idx       = ent[PIN_W-1:0];

    always_comb begin
        kind = ACC_UNMAPPED;
        if (offset == OFF_SELECT) begin
            kind = ACC_SELECT;
        end else if (offset == OFF_WINDOW) begin
            if (sel == IDX_IDENT)        kind = ACC_IDENT;
            else if (sel == IDX_VERSION) kind = ACC_VERSION;
            else if (sel == IDX_ARBIT)   kind = ACC_ARBIT;
            else if (sel >= IDX_TBL_BASE && ent < 7'(NUM_PINS))
                kind = sel[0] ? ACC_ENT_HI : ACC_ENT_LO;
        end
    end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [PIN_W-1:0]    wr_idx,
    input  logic [31:0]         wdata,
    input  logic [PIN_W-1:0]    rd_idx,
    input  logic                rd_hi,
    output logic [31:0]         rd_word,
    output logic [NUM_PINS-1:0] mask_vec,
    output logic                mask_chg_valid,
    output logic [PIN_W-1:0]    mask_chg_pin,
    output logic                mask_chg_value
);
    localparam logic [63:0] ENT_RESET = 64'(1) << MASK_BIT;
    localparam logic [31:0] LO_KEEP   = ~(32'(1) << RACK_BIT);

    logic [63:0] ent_w [NUM_PINS];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        logic [63:0] ent_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_r <= ENT_RESET;
            end else if (wr_lo && wr_idx == PIN_W'(g)) begin
                ent_r[31:0] <= wdata & LO_KEEP;
            end else if (wr_hi && wr_idx == PIN_W'(g)) begin
                ent_r[63:32] <= wdata;
            end
        end
        assign ent_w[g]    = ent_r;
        assign mask_vec[g] = ent_r[MASK_BIT];
    end

    assign rd_word = rd_hi ? ent_w[rd_idx][63:32] : ent_w[rd_idx][31:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_chg_valid <= 1'b0;
            mask_chg_pin   <= '0;
            mask_chg_value <= 1'b0;
        end else begin
            mask_chg_valid <= wr_lo && (wdata[MASK_BIT] != mask_vec[wr_idx]);
            if (wr_lo) begin
                mask_chg_pin   <= wr_idx;
                mask_chg_value <= wdata[MASK_BIT];
            end
        end
    end
endmodule

// File: rtl/irq_route_pending.sv
module irq_route_pending #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pend_set,
    input  logic [NUM_PINS-1:0] pend_clr,
    input  logic                ent_wr,
    input  logic [PIN_W-1:0]    wr_idx,
    output logic [NUM_PINS-1:0] pend_q,
    output logic                svc_valid,
    output logic [PIN_W-1:0]    svc_pin
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            svc_valid <= 1'b0;
            svc_pin   <= '0;
        end else begin
            pend_q    <= (pend_q & ~pend_clr) | pend_set;
            svc_valid <= ent_wr && pend_q[wr_idx];
            if (ent_wr) svc_pin <= wr_idx;
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_len,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pend_set,
    input  logic [NUM_PINS-1:0] pend_clr,
    output logic                svc_valid,
    output logic [PIN_W-1:0]    svc_pin,
    output logic                mask_chg_valid,
    output logic [PIN_W-1:0]    mask_chg_pin,
    output logic                mask_chg_value
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

    logic [7:0]          sel_q;
    logic [3:0]          id_q;
    acc_kind_e           kind;
    logic [PIN_W-1:0]    idx;
    logic                wr_ok;
    logic                wr_lo;
    logic                wr_hi;
    logic [31:0]         ent_word;
    logic [NUM_PINS-1:0] mask_vec;
    logic [NUM_PINS-1:0] pend_q;

    assign wr_ok = bus_wr_en && (bus_len == 4'd4 || bus_len == 4'd8);
    assign wr_lo = wr_ok && kind == ACC_ENT_LO;
    assign wr_hi = wr_ok && kind == ACC_ENT_HI;

    irq_route_decode #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel_q),
        .kind (kind),
        .idx  (idx)
    );

    irq_route_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_lo          (wr_lo),
        .wr_hi          (wr_hi),
        .wr_idx         (idx),
        .wdata          (bus_wdata),
        .rd_idx         (idx),
        .rd_hi          (kind == ACC_ENT_HI),
        .rd_word        (ent_word),
        .mask_vec       (mask_vec),
        .mask_chg_valid (mask_chg_valid),
        .mask_chg_pin   (mask_chg_pin),
        .mask_chg_value (mask_chg_value)
    );

    irq_route_pending #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_set  (pend_set),
        .pend_clr  (pend_clr),
        .ent_wr    (wr_lo || wr_hi),
        .wr_idx    (idx),
        .pend_q    (pend_q),
        .svc_valid (svc_valid),
        .svc_pin   (svc_pin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else if (wr_ok) begin
            if (kind == ACC_SELECT) sel_q <= bus_wdata[7:0];
            if (kind == ACC_IDENT)  id_q  <= bus_wdata[27:24];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (!bus_rd_en) begin
            bus_rdata <= '0;
        end else begin
            unique case (kind)
                ACC_SELECT:             bus_rdata <= {24'h0, sel_q};
                ACC_IDENT, ACC_ARBIT:   bus_rdata <= {4'h0, id_q, 24'h0};
                ACC_VERSION:            bus_rdata <= VER_WORD;
                ACC_ENT_LO, ACC_ENT_HI: bus_rdata <= ent_word;
                default:                bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr_en,
    input logic                bus_rd_en,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [3:0]          bus_len,
    input logic [31:0]         bus_rdata,
    input logic [7:0]          sel_q,
    input logic [NUM_PINS-1:0] mask_vec,
    input logic                svc_valid,
    input logic                mask_chg_valid,
    input logic [PIN_W-1:0]    mask_chg_pin,
    input logic                mask_chg_value
);
    localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_PINS - 1), 8'h00, 8'h11};
    localparam logic [7:0]  SEL_END = 8'(8'h10 + 2 * NUM_PINS);

    logic win_hit;
    logic len_ok;
    assign win_hit = bus_addr[7:0] == 8'h10;
    assign len_ok  = bus_len == 4'd4 || bus_len == 4'd8;

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> bus_rdata == 32'h0);

    a_r3_version_word: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en && win_hit && sel_q == 8'h01 |=> bus_rdata == VER_EXP);

    a_r8_notice_matches: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> (32'(mask_chg_pin) < NUM_PINS) && mask_chg_value == mask_vec[mask_chg_pin]);

    a_r8_notice_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> $past(bus_wr_en && win_hit && sel_q >= 8'h10));

    a_r9_svc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> $past(bus_wr_en && win_hit && sel_q >= 8'h10));

    a_r7_out_of_range_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en && win_hit && sel_q >= SEL_END |=> !mask_chg_valid && !svc_valid);

    a_r10_bad_len_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en && !len_ok |=> $stable(sel_q) && $stable(mask_vec) && !svc_valid);
endmodule

bind irq_route_regs irq_route_chk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr_en      (bus_wr_en),
    .bus_rd_en      (bus_rd_en),
    .bus_addr       (bus_addr),
    .bus_len        (bus_len),
    .bus_rdata      (bus_rdata),
    .sel_q          (sel_q),
    .mask_vec       (mask_vec),
    .svc_valid      (svc_valid),
    .mask_chg_valid (mask_chg_valid),
    .mask_chg_pin   (mask_chg_pin),
    .mask_chg_value (mask_chg_value)
);

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;
    localparam int ADDR_W   = 12;
    localparam int NUM_PINS = 24;
    localparam int PIN_W    = 5;
    localparam int NVEC     = 33;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [3:0]  len;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Reads check exp; writes only drive. req is the requirement number checked.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h000, 4'd4, 32'h0,        32'h00000000, 4'd1},  // R1 select cleared
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00000000, 4'd1},  // R1 ID cleared
        '{1'b1, 12'h000, 4'd4, 32'h01,       32'h0,        4'd2},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00170011, 4'd3},  // R3
        '{1'b1, 12'h010, 4'd4, 32'hFFFFFFFF, 32'h0,        4'd3},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00170011, 4'd3},  // R3 write ignored
        '{1'b0, 12'h000, 4'd4, 32'h0,        32'h00000001, 4'd2},  // R2
        '{1'b1, 12'h000, 4'd4, 32'h00,       32'h0,        4'd4},
        '{1'b1, 12'h010, 4'd4, 32'hA5000000, 32'h0,        4'd4},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h05000000, 4'd4},  // R4 ID field only
        '{1'b1, 12'h000, 4'd4, 32'h02,       32'h0,        4'd4},
        '{1'b1, 12'h010, 4'd4, 32'h0F000000, 32'h0,        4'd4},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h05000000, 4'd4},  // R4 arbitration
        '{1'b1, 12'h000, 4'd4, 32'h10,       32'h0,        4'd1},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00010000, 4'd1},  // R1 mask set
        '{1'b1, 12'h010, 4'd4, 32'h00004031, 32'h0,        4'd6},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00000031, 4'd6},  // R6 flag cleared
        '{1'b1, 12'h000, 4'd4, 32'h11,       32'h0,        4'd5},
        '{1'b1, 12'h010, 4'd4, 32'hAB000000, 32'h0,        4'd5},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'hAB000000, 4'd5},  // R5 high half
        '{1'b1, 12'h000, 4'd4, 32'h10,       32'h0,        4'd5},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00000031, 4'd5},  // R5 low untouched
        '{1'b1, 12'h000, 4'd2, 32'h13,       32'h0,        4'd10},
        '{1'b0, 12'h000, 4'd4, 32'h0,        32'h00000010, 4'd10}, // R10 len 2 dropped
        '{1'b1, 12'h000, 4'd8, 32'h3E,       32'h0,        4'd10},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00010000, 4'd5},  // R5 last entry, R10 len 8
        '{1'b1, 12'h000, 4'd4, 32'h40,       32'h0,        4'd7},
        '{1'b1, 12'h010, 4'd4, 32'h12345678, 32'h0,        4'd7},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00000000, 4'd7},  // R7
        '{1'b0, 12'h020, 4'd4, 32'h0,        32'h00000000, 4'd11}, // R11 undecoded
        '{1'b0, 12'h100, 4'd4, 32'h0,        32'h00000040, 4'd11}, // R11 high bits ignored
        '{1'b1, 12'h000, 4'd4, 32'h05,       32'h0,        4'd11},
        '{1'b0, 12'h010, 4'd4, 32'h0,        32'h00000000, 4'd11}  // R11 reserved select
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_wr_en = 1'b0;
    logic                bus_rd_en = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [3:0]          bus_len = 4'd4;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NUM_PINS-1:0] pend_set = '0;
    logic [NUM_PINS-1:0] pend_clr = '0;
    logic                svc_valid;
    logic [PIN_W-1:0]    svc_pin;
    logic                mask_chg_valid;
    logic [PIN_W-1:0]    mask_chg_pin;
    logic                mask_chg_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_route_regs #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) i_irq_route_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_set(pend_set), .pend_clr(pend_clr),
        .svc_valid(svc_valid), .svc_pin(svc_pin),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
        .mask_chg_value(mask_chg_value)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [3:0] l, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_len = l; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_len = 4'd4;
    endtask

    task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse_pend(input int pin, input bit set);
        @(negedge clk);
        if (set) pend_set[pin] = 1'b1; else pend_clr[pin] = 1'b1;
        @(negedge clk);
        pend_set = '0; pend_clr = '0;
    endtask

    // Checks notices sampled right after a write returns.
    task automatic chk_notice(input string req, input bit mv, input int mp, input bit mval,
                              input bit sv, input int sp);
        check(mask_chg_valid == mv, req, 32'(mask_chg_valid), 32'(mv));
        if (mv) check(mask_chg_pin == PIN_W'(mp) && mask_chg_value == mval, req,
                      {mask_chg_value, 26'h0, mask_chg_pin}, {mval, 26'h0, 5'(mp)});
        check(svc_valid == sv, req, 32'(svc_valid), 32'(sv));
        if (sv) check(svc_pin == PIN_W'(sp), req, 32'(svc_pin), 32'(sp));
    endtask

    initial begin
        logic [31:0] rd;
        do_reset();
        @(negedge clk);
        check(bus_rdata == 0 && !svc_valid && !mask_chg_valid, "R1 outputs idle",
              bus_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) begin
                do_wr(VECS[i].addr, VECS[i].len, VECS[i].data);
            end else begin
                do_rd(VECS[i].addr, rd);
                check(rd == VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i),
                      rd, VECS[i].exp);
            end
        end

        do_reset();
        // R8: unmask pin 1, no pending so no service (R9)
        do_wr(12'h000, 4'd4, 32'h12);
        do_wr(12'h010, 4'd4, 32'h00000040);
        chk_notice("R8 unmask pin1", 1'b1, 1, 1'b0, 1'b0, 0);
        do_wr(12'h010, 4'd4, 32'h00000041);
        chk_notice("R8 mask unchanged", 1'b0, 0, 1'b0, 1'b0, 0);
        // R9: pending pin 1, then masking write
        pulse_pend(1, 1'b1);
        do_wr(12'h010, 4'd4, 32'h00010041);
        chk_notice("R9 pending service", 1'b1, 1, 1'b1, 1'b1, 1);
        do_wr(12'h000, 4'd4, 32'h13);
        do_wr(12'h010, 4'd4, 32'h0F000000);
        chk_notice("R9 high-half service", 1'b0, 0, 1'b0, 1'b1, 1);
        pulse_pend(1, 1'b0);
        do_wr(12'h010, 4'd4, 32'h0E000000);
        chk_notice("R9 cleared pending", 1'b0, 0, 1'b0, 1'b0, 0);
        // R8/R9 last pin
        pulse_pend(23, 1'b1);
        do_wr(12'h000, 4'd4, 32'h3E);
        do_wr(12'h010, 4'd4, 32'h00000000);
        chk_notice("R8 R9 pin 23", 1'b1, 23, 1'b0, 1'b1, 23);
        // R7: out-of-range write silent
        do_wr(12'h000, 4'd4, 32'h40);
        do_wr(12'h010, 4'd4, 32'h00000000);
        chk_notice("R7 out of range", 1'b0, 0, 1'b0, 1'b0, 0);
        // R10: length 1 entry write dropped
        do_wr(12'h000, 4'd4, 32'h3E);
        do_wr(12'h010, 4'd1, 32'h00010000);
        chk_notice("R10 short write", 1'b0, 0, 1'b0, 1'b0, 0);
        do_rd(12'h010, rd);
        check(rd == 32'h0, "R10 entry unchanged", rd, 32'h0);
        // R1: reset clears pending and restores masks
        pulse_pend(2, 1'b1);
        do_reset();
        do_rd(12'h000, rd);
        check(rd == 32'h0, "R1 select after reset", rd, 32'h0);
        do_wr(12'h000, 4'd4, 32'h14);
        do_wr(12'h010, 4'd4, 32'h00000000);
        chk_notice("R1 pending cleared mask set", 1'b1, 2, 1'b0, 1'b0, 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule